// File: doc/BRIEF.md
# Thread Phase and Resource Activity Classifier

This block sits beside the rename and dispatch logic of a simultaneous multithreaded core with up to four hardware threads. For each thread it counts outstanding L1 data-cache misses. A thread with at least one outstanding miss is in a slow phase, and a thread with none is in a fast phase. The counter rises on a miss-detect pulse and falls on a miss-service pulse.

For each floating-point resource type, every thread has an idle timer. The resource types are the FP issue queue (index 0) and the FP physical registers (index 1). The timer is reloaded whenever the thread allocates an entry of that resource. It counts down by one on each cycle without such an allocation. When it reaches zero, the thread is inactive for that resource until it allocates again.

Phase and activity combine into one 2-bit class per thread and resource. The block also reports two group counts for each resource: running fast-active threads and running slow-active threads. It gives the same counts for resources without an idle timer, where every running thread counts as active. A downstream allocation table uses these counts to split entries between threads.

Top module: `thread_class_unit`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every miss count is zero and every idle timer holds `ACT_RELOAD`. All classes therefore read fast-active and all `slow_o` bits are 0.
- R2: A miss-detect pulse on thread t raises that thread's miss count by one. `slow_o[t]` is 1 from the cycle after the clock edge that samples the pulse, for as long as the count is non-zero.
- R3: A miss-service pulse lowers the miss count by one. The thread returns to fast (`slow_o[t]`=0) in the cycle after the count reaches zero.
- R4: A detect and a service pulse on the same thread in the same cycle leave its miss count unchanged.
- R5: A service pulse while the miss count is zero is ignored. The count stays at zero and does not wrap.
- R6: An idle timer decrements on every clock edge at which its thread does not allocate that resource. Starting from a reload, the thread reads inactive after exactly `ACT_RELOAD` such edges, and not before.
- R7: An allocation strobe reloads the timer. A thread that was inactive reads active from the cycle after the edge that samples the strobe.
- R8: Activity is kept separately for each resource. `alloc_i` bit t*N_RES+r affects only thread t, resource r.
- R9: Class field t*N_RES+r occupies `class_o[2*(t*N_RES+r)+:2]`. Bit 1 of the field is the slow phase and bit 0 is inactive, so 00 is fast-active, 01 fast-inactive, 10 slow-active and 11 slow-inactive.
- R10: `fa_cnt_o[CNT_W*r+:CNT_W]` and `sa_cnt_o[CNT_W*r+:CNT_W]` count the threads with `run_i` set that are fast-active and slow-active for resource r. Threads with `run_i` clear are not counted.
- R11: `fast_run_o` and `slow_run_o` count running fast threads and running slow threads regardless of activity. These are the group counts for resources without an idle timer.
- R12: The miss count saturates at 2^MISS_W-1. Extra detects at that value are dropped, so the same number of services returns the thread to fast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | N_THR | Thread is running and takes part in group counts |
| miss_det_i | input | N_THR | New L1 data miss detected for thread, one pulse per miss |
| miss_svc_i | input | N_THR | L1 data miss serviced for thread, one pulse per miss |
| alloc_i | input | N_THR*N_RES | Thread t allocates an entry of resource r this cycle (bit t*N_RES+r) |
| slow_o | output | N_THR | Thread is in a slow phase |
| class_o | output | 2*N_THR*N_RES | Class per thread and resource, encoded as in R9 |
| fa_cnt_o | output | CNT_W*N_RES | Running fast-active thread count per resource |
| sa_cnt_o | output | CNT_W*N_RES | Running slow-active thread count per resource |
| fast_run_o | output | CNT_W | Running fast threads |
| slow_run_o | output | CNT_W | Running slow threads |

## Verification
Several miss-pulse patterns are applied, and each separates a different miscount of the pending-miss counter:
- nested detects followed by services in turn, which show whether the count has one step of depth;
- a detect paired with a service in the same cycle, which shows whether one of the two pulses wins;
- services while the count is zero, which show whether the counter wraps;
- a burst of detects past the counter's maximum, which shows whether it saturates.

The idle timers are run for one cycle less than the reload value and then for exactly the reload value. This tells an off-by-one decrement from a correct one. A single strobe on one thread and resource shows that activity does not leak between resources or threads. A partial running mask shows whether the group counts include stopped threads.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  // bit1 = slow phase, bit0 = inactive
  typedef enum logic [1:0] {
    CLS_FA = 2'b00,
    CLS_FI = 2'b01,
    CLS_SA = 2'b10,
    CLS_SI = 2'b11
  } cls_e;

  function automatic cls_e make_cls(input logic slow, input logic inact);
    return cls_e'({slow, inact});
  endfunction
endpackage

// File: rtl/tcu_miss_tracker.sv
module tcu_miss_tracker #(
  parameter int MISS_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  input  logic svc_i,
  output logic slow_o
);
  localparam logic [MISS_W-1:0] CNT_MAX = '1;
  localparam logic [MISS_W-1:0] CNT_ONE = MISS_W'(1);

  logic [MISS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({det_i, svc_i})
      2'b10: if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
      2'b01: if (cnt_q != '0)      cnt_d = cnt_q - CNT_ONE;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign slow_o = (cnt_q != '0);

  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && !det_i && !slow_o) |=> !slow_o);
  // R4
  pair_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && det_i) |=> $stable(cnt_q));
  // R12
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i && !svc_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
  // R2
  det_slow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i && !svc_i) |=> slow_o);
endmodule

// File: rtl/tcu_activity_tracker.sv
module tcu_activity_tracker #(
  parameter int ACT_RELOAD = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alloc_i,
  output logic inact_o
);
  localparam int ACT_W = $clog2(ACT_RELOAD + 1);
  localparam logic [ACT_W-1:0] RELOAD_V = ACT_W'(ACT_RELOAD);
  localparam logic [ACT_W-1:0] ONE_V    = ACT_W'(1);

  logic [ACT_W-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            tmr_q <= RELOAD_V;
    else if (alloc_i)       tmr_q <= RELOAD_V;
    else if (tmr_q != '0)   tmr_q <= tmr_q - ONE_V;
  end

  assign inact_o = (tmr_q == '0);

  // R7
  reactivate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> !inact_o);
  // R6
  idle_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(inact_o) |-> $past(!alloc_i));
endmodule

// File: rtl/tcu_group_counter.sv
module tcu_group_counter #(
  parameter int N_THR = 4,
  parameter int CNT_W = $clog2(N_THR + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_THR-1:0] run_i,
  input  logic [N_THR-1:0] slow_i,
  input  logic [N_THR-1:0] inact_i,
  output logic [CNT_W-1:0] fa_o,
  output logic [CNT_W-1:0] sa_o
);
  always_comb begin
    fa_o = '0;
    sa_o = '0;
    for (int t = 0; t < N_THR; t++) begin
      if (run_i[t] && !inact_i[t]) begin
        if (slow_i[t]) sa_o = sa_o + CNT_W'(1);
        else           fa_o = fa_o + CNT_W'(1);
      end
    end
  end

  // R10
  grp_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(fa_o) + int'(sa_o)) <= $countones(run_i));
endmodule

// File: rtl/thread_class_unit.sv
module thread_class_unit
  import tcu_pkg::*;
#(
  parameter int N_THR      = 4,
  parameter int N_RES      = 2,
  parameter int MISS_W     = 4,
  parameter int ACT_RELOAD = 256,
  localparam int CNT_W     = $clog2(N_THR + 1),
  localparam int N_FLD     = N_THR * N_RES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_THR-1:0]       run_i,
  input  logic [N_THR-1:0]       miss_det_i,
  input  logic [N_THR-1:0]       miss_svc_i,
  input  logic [N_FLD-1:0]       alloc_i,
  output logic [N_THR-1:0]       slow_o,
  output logic [2*N_FLD-1:0]     class_o,
  output logic [CNT_W*N_RES-1:0] fa_cnt_o,
  output logic [CNT_W*N_RES-1:0] sa_cnt_o,
  output logic [CNT_W-1:0]       fast_run_o,
  output logic [CNT_W-1:0]       slow_run_o
);
  logic [N_THR-1:0] slow_w;
  logic [N_THR-1:0] inact_w [N_RES];

  for (genvar t = 0; t < N_THR; t++) begin : g_thr
    tcu_miss_tracker #(.MISS_W(MISS_W)) u_miss (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .det_i (miss_det_i[t]),
      .svc_i (miss_svc_i[t]),
      .slow_o(slow_w[t])
    );
    for (genvar r = 0; r < N_RES; r++) begin : g_res
      tcu_activity_tracker #(.ACT_RELOAD(ACT_RELOAD)) u_act (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .alloc_i(alloc_i[t*N_RES+r]),
        .inact_o(inact_w[r][t])
      );
      assign class_o[2*(t*N_RES+r) +: 2] = make_cls(slow_w[t], inact_w[r][t]);
    end
  end

  for (genvar r = 0; r < N_RES; r++) begin : g_grp
    tcu_group_counter #(.N_THR(N_THR), .CNT_W(CNT_W)) u_grp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .slow_i (slow_w),
      .inact_i(inact_w[r]),
      .fa_o   (fa_cnt_o[CNT_W*r +: CNT_W]),
      .sa_o   (sa_cnt_o[CNT_W*r +: CNT_W])
    );
  end

  // untracked resources: every running thread is active
  tcu_group_counter #(.N_THR(N_THR), .CNT_W(CNT_W)) u_grp_all (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .slow_i (slow_w),
    .inact_i('0),
    .fa_o   (fast_run_o),
    .sa_o   (slow_run_o)
  );

  assign slow_o = slow_w;

  // R2
  phase_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_det_i == '0 && miss_svc_i == '0) |=> $stable(slow_o));
  // R11
  run_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(fast_run_o) + int'(slow_run_o)) == $countones(run_i));
endmodule

// File: tb/sim_thread_class_unit.sv
`timescale 1ns/1ps
module sim_thread_class_unit;
  localparam int N_THR = 4;
  localparam int N_RES = 2;
  localparam int RELOAD = 256;
  localparam int CW = 3;

  logic clk = 0;
  logic rst_ni = 0;
  logic [N_THR-1:0] run_i = '1;
  logic [N_THR-1:0] miss_det_i = '0;
  logic [N_THR-1:0] miss_svc_i = '0;
  logic [N_THR*N_RES-1:0] alloc_i = '0;
  logic [N_THR-1:0] slow_o;
  logic [2*N_THR*N_RES-1:0] class_o;
  logic [CW*N_RES-1:0] fa_cnt_o, sa_cnt_o;
  logic [CW-1:0] fast_run_o, slow_run_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  thread_class_unit #(.N_THR(N_THR), .N_RES(N_RES), .MISS_W(4), .ACT_RELOAD(RELOAD)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .miss_det_i(miss_det_i),
    .miss_svc_i(miss_svc_i), .alloc_i(alloc_i), .slow_o(slow_o), .class_o(class_o),
    .fa_cnt_o(fa_cnt_o), .sa_cnt_o(sa_cnt_o), .fast_run_o(fast_run_o), .slow_run_o(slow_run_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cls(input int t, input int r);
    return int'(class_o[2*(t*N_RES+r) +: 2]);
  endfunction

  task automatic do_reset(input logic [N_THR*N_RES-1:0] alloc_v);
    @(negedge clk);
    rst_ni = 0; miss_det_i = '0; miss_svc_i = '0; run_i = '1; alloc_i = alloc_v;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
  endtask

  // drive one cycle of pulses at negedge, leave at next negedge
  task automatic pulse(input logic [N_THR-1:0] det, input logic [N_THR-1:0] svc);
    miss_det_i = det; miss_svc_i = svc;
    @(posedge clk);
    @(negedge clk);
    miss_det_i = '0; miss_svc_i = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_ni = 0;
    #1;
    chk("R1 class during reset", int'(class_o), 0);
    do_reset('1);
    chk("R1 class", int'(class_o), 0);
    chk("R1 slow", int'(slow_o), 0);
    chk("R1 fa r0", int'(fa_cnt_o[0+:CW]), 4);
    chk("R1 sa r1", int'(sa_cnt_o[CW+:CW]), 0);
  endtask

  task automatic t_nested;
    do_reset('1);
    pulse(4'b0010, 4'b0000);
    chk("R2 slow after detect", int'(slow_o), 2);
    chk("R9 class t1 r0 slow-active", cls(1, 0), 2);
    chk("R10 sa r0", int'(sa_cnt_o[0+:CW]), 1);
    chk("R10 fa r0", int'(fa_cnt_o[0+:CW]), 3);
    chk("R11 slow_run", int'(slow_run_o), 1);
    pulse(4'b0010, 4'b0000);
    pulse(4'b0000, 4'b0010);
    chk("R3 still slow one pending", int'(slow_o), 2);
    pulse(4'b0000, 4'b0010);
    chk("R3 fast at zero", int'(slow_o), 0);
  endtask

  task automatic t_pair;
    do_reset('1);
    pulse(4'b0100, 4'b0000);
    pulse(4'b0100, 4'b0100);
    chk("R4 pair keeps one", int'(slow_o), 4);
    pulse(4'b0000, 4'b0100);
    chk("R4 single svc clears", int'(slow_o), 0);
    pulse(4'b0100, 4'b0100);
    chk("R4 pair at zero", int'(slow_o), 0);
  endtask

  task automatic t_underflow;
    do_reset('1);
    for (int i = 0; i < 3; i++) pulse(4'b0000, 4'b0001);
    chk("R5 svc at zero ignored", int'(slow_o), 0);
    pulse(4'b0001, 4'b0000);
    pulse(4'b0000, 4'b0001);
    chk("R5 no wrap", int'(slow_o), 0);
  endtask

  task automatic t_sat;
    do_reset('1);
    for (int i = 0; i < 20; i++) pulse(4'b1000, 4'b0000);
    for (int i = 0; i < 14; i++) pulse(4'b0000, 4'b1000);
    chk("R12 slow before last svc", int'(slow_o), 8);
    pulse(4'b0000, 4'b1000);
    chk("R12 fast after 15 svc", int'(slow_o), 0);
  endtask

  task automatic t_activity;
    do_reset(8'b0000_0001);
    repeat (RELOAD - 1) @(posedge clk);
    @(negedge clk);
    chk("R6 t1 r0 active one edge early", cls(1, 0), 0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 t1 r0 inactive", cls(1, 0), 1);
    chk("R8 t0 r0 kept active", cls(0, 0), 0);
    chk("R8 t0 r1 inactive", cls(0, 1), 1);
    chk("R10 fa r0", int'(fa_cnt_o[0+:CW]), 1);
    chk("R10 fa r1", int'(fa_cnt_o[CW+:CW]), 0);
    alloc_i = 8'b0000_0101;
    @(posedge clk);
    @(negedge clk);
    alloc_i = 8'b0000_0001;
    chk("R7 t1 r0 reactivated", cls(1, 0), 0);
    chk("R8 t1 r1 still inactive", cls(1, 1), 1);
    pulse(4'b0010, 4'b0000);
    chk("R9 t1 r1 slow-inactive", cls(1, 1), 3);
  endtask

  task automatic t_runmask;
    do_reset('1);
    run_i = 4'b0101;
    pulse(4'b0001, 4'b0000);
    chk("R10 fa r1 masked", int'(fa_cnt_o[CW+:CW]), 1);
    chk("R10 sa r1 masked", int'(sa_cnt_o[CW+:CW]), 1);
    chk("R11 fast_run", int'(fast_run_o), 1);
    chk("R11 slow_run", int'(slow_run_o), 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_nested();
    t_pair();
    t_underflow();
    t_sat();
    t_activity();
    t_runmask();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule